// File: doc/BRIEF.md
# Vendor Memory-Dump Mode Controller

This block watches a stream of already-decoded card commands (a valid strobe, a 6-bit command index and a 32-bit argument). It hides a vendor mode in which standard commands take on new meanings. In this mode, the erase-group commands set up a window of internal memory, the erase command arms that window, and the single-block read streams the window out byte by byte. The mode is entered and left only through a two-command keyed sequence on vendor command 62. Outside the mode, every command is forwarded unchanged on a registered passthrough port.

While the mode is active, the commands the block has taken over are held back from the passthrough port. In particular, an erase never reaches the real erase path. An inhibit output tells downstream logic that the mode is on. A read produces exactly one 512-byte block on a valid/ready byte stream. The bytes come from a simple memory read port with one cycle of latency. Bytes beyond the programmed length are zero.

Top module: `dbgdump_ctrl`

## Requirements
- R1: After synchronous reset: `mode_active`, `erase_inhibit`, `pass_valid`, `rd_error`, `mem_req` and `dout_valid` are all 0.
- R2: While the mode is inactive, every command (including index 62) appears on `pass_valid`/`pass_index`/`pass_arg` one cycle after its `cmd_valid` cycle, with index and argument unchanged.
- R3: Entry sequence: while inactive, a command 62 with argument 0xEFAC62EC, whose next valid command is command 62 with argument 0x10210002, sets `mode_active` from the cycle after that second command.
- R4: If the command after a 0xEFAC62EC key is anything other than the expected partner, the key is discarded. The mode stays as it was, and a later partner command alone does nothing. The mismatching command itself is handled as in the current mode.
- R5: Exit sequence: while active, command 62 with argument 0xEFAC62EC, followed by command 62 with argument 0x00DECCEE as the next command, clears `mode_active` from the cycle after the second command.
- R6: While active, `erase_inhibit` is 1. Commands 17, 35, 36, 38 and 62 are consumed and never forwarded; in particular, command 38 never appears on the passthrough port. All other indices are forwarded as in R2.
- R7: While active, command 35 latches its argument (low address bits) as the window start, and command 36 latches its argument as the window length. Either one disarms the window. Command 38 with argument 0 arms the window; command 38 with any nonzero argument leaves the armed state unchanged.
- R8: While active, command 17 with the window armed and no stream running emits 512 bytes. Byte k equals memory at (start + k) modulo the address space for k < length, and 0 otherwise. `dout_last` marks byte 511. Memory data returns one cycle after `mem_req`.
- R9: While `dout_valid` is 1 and `dout_ready` is 0, `dout_valid`, `dout_data` and `dout_last` hold steady into the next cycle.
- R10: While active, command 17 with the window unarmed or a stream already running produces a one-cycle `rd_error` pulse, in the cycle after the command, and starts no stream.
- R11: Leaving the mode disarms the window, so after re-entry a read fails as in R10 until the window is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| pass_valid | output | 1 | Forwarded command strobe |
| pass_index | output | 6 | Forwarded command index |
| pass_arg | output | 32 | Forwarded command argument |
| erase_inhibit | output | 1 | Real erase path must stay idle |
| mode_active | output | 1 | Vendor dump mode is on |
| rd_error | output | 1 | Read refused, one-cycle pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 8 | Memory read data, one cycle after request |
| dout_valid | output | 1 | Output byte valid |
| dout_data | output | 8 | Output byte |
| dout_last | output | 1 | Final byte of the block |
| dout_ready | input | 1 | Consumer accepts byte |

## Verification
The bench aims at the keyed sequencer. It sends a key followed by a wrong partner, a wrong index, and a lone partner. A sequencer that kept a stale key would enter or leave the mode on the lone partner. It checks that a nonzero erase argument does not arm the window; a design that armed on any erase would stream data where an error is due. The streams cover a length shorter than the block, a length longer than the block, a zero length and an address that wraps. They run under random-looking backpressure, so that a missing zero pad, a missed clamp, an off-by-one on the last flag or data changing during a stall each show up as a byte miscompare. Reads issued before arming, during a stream and after re-entry must raise the error pulse instead of data.

// File: rtl/dbgdump_pkg.sv
package dbgdump_pkg;

    localparam int ARG_W  = 32;
    localparam int IDX_W  = 6;
    localparam int BYTE_W = 8;

    localparam logic [IDX_W-1:0] CMD_READ_ONE    = 6'd17;
    localparam logic [IDX_W-1:0] CMD_GROUP_START = 6'd35;
    localparam logic [IDX_W-1:0] CMD_GROUP_END   = 6'd36;
    localparam logic [IDX_W-1:0] CMD_ERASE       = 6'd38;
    localparam logic [IDX_W-1:0] CMD_VENDOR      = 6'd62;

    localparam logic [ARG_W-1:0] KEY_UNLOCK = 32'hEFAC_62EC;
    localparam logic [ARG_W-1:0] KEY_ENTER  = 32'h1021_0002;
    localparam logic [ARG_W-1:0] KEY_LEAVE  = 32'h00DE_CCEE;

    typedef enum logic [1:0] {
        SEQ_OFF       = 2'd0,
        SEQ_OFF_KEYED = 2'd1,
        SEQ_ON        = 2'd2,
        SEQ_ON_KEYED  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_SEND  = 2'd3
    } strm_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic [ARG_W-1:0] arg;
    } mmc_cmd_t;

    function automatic logic is_vendor(mmc_cmd_t c, logic [ARG_W-1:0] key);
        return (c.index == CMD_VENDOR) && (c.arg == key);
    endfunction

    function automatic logic is_taken_over(logic [IDX_W-1:0] idx);
        logic r;
        case (idx)
            CMD_READ_ONE, CMD_GROUP_START, CMD_GROUP_END,
            CMD_ERASE, CMD_VENDOR: r = 1'b1;
            default:               r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbgdump_keyseq.sv
module dbgdump_keyseq
    import dbgdump_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  mmc_cmd_t cmd,
    output logic     mode_active
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            case (state_q)
                SEQ_OFF:       if (is_vendor(cmd, KEY_UNLOCK)) state_d = SEQ_OFF_KEYED;
                SEQ_OFF_KEYED: state_d = is_vendor(cmd, KEY_ENTER) ? SEQ_ON : SEQ_OFF;
                SEQ_ON:        if (is_vendor(cmd, KEY_UNLOCK)) state_d = SEQ_ON_KEYED;
                SEQ_ON_KEYED:  state_d = is_vendor(cmd, KEY_LEAVE) ? SEQ_OFF : SEQ_ON;
                default:       state_d = SEQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_OFF;
        else     state_q <= state_d;
    end

    assign mode_active = (state_q == SEQ_ON) || (state_q == SEQ_ON_KEYED);

    // R3: a matched entry pair turns the mode on
    p_enter_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && state_q == SEQ_OFF_KEYED && is_vendor(cmd, KEY_ENTER)) |=> mode_active);

    // R4: an unmatched partner drops the key without changing the mode
    p_mismatch_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && state_q == SEQ_OFF_KEYED && !is_vendor(cmd, KEY_ENTER)) |=> state_q == SEQ_OFF);

    // R5: a matched exit pair turns the mode off
    p_leave_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && state_q == SEQ_ON_KEYED && is_vendor(cmd, KEY_LEAVE)) |=> !mode_active);

endmodule

// File: rtl/dbgdump_window.sv
module dbgdump_window
    import dbgdump_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  mmc_cmd_t         cmd,
    input  logic             mode_active,
    input  logic             strm_busy,
    output logic             pass_valid,
    output mmc_cmd_t         pass_cmd,
    output logic             rd_error,
    output logic             strm_start,
    output logic [AW-1:0]    win_addr,
    output logic [ARG_W-1:0] win_len
);

    logic armed_q;
    logic read_hit;

    assign read_hit   = cmd_valid && mode_active && (cmd.index == CMD_READ_ONE);
    assign strm_start = read_hit && armed_q && !strm_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_valid <= 1'b0;
            pass_cmd   <= '0;
            rd_error   <= 1'b0;
            armed_q    <= 1'b0;
            win_addr   <= '0;
            win_len    <= '0;
        end else begin
            pass_valid <= cmd_valid && (!mode_active || !is_taken_over(cmd.index));
            if (cmd_valid && (!mode_active || !is_taken_over(cmd.index)))
                pass_cmd <= cmd;
            rd_error <= read_hit && !(armed_q && !strm_busy);
            if (!mode_active) begin
                armed_q <= 1'b0;
            end else if (cmd_valid) begin
                case (cmd.index)
                    CMD_GROUP_START: begin
                        win_addr <= cmd.arg[AW-1:0];
                        armed_q  <= 1'b0;
                    end
                    CMD_GROUP_END: begin
                        win_len <= cmd.arg;
                        armed_q <= 1'b0;
                    end
                    CMD_ERASE: if (cmd.arg == '0) armed_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // R7: a nonzero erase argument leaves the armed state alone
    p_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && mode_active && cmd.index == CMD_ERASE && cmd.arg != '0)
        |=> armed_q == $past(armed_q));

    // R10: a read without an armed idle window raises the error pulse
    p_refuse_r10: assert property (@(posedge clk) disable iff (rst)
        (read_hit && (!armed_q || strm_busy)) |=> rd_error);

    // R11: leaving the mode disarms the window
    p_disarm_r11: assert property (@(posedge clk) disable iff (rst)
        !mode_active |=> !armed_q);

endmodule

// File: rtl/dbgdump_stream.sv
module dbgdump_stream
    import dbgdump_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BLK_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strm_start,
    input  logic [AW-1:0]     win_addr,
    input  logic [ARG_W-1:0]  win_len,
    output logic              strm_busy,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              dout_valid,
    output logic [BYTE_W-1:0] dout_data,
    output logic              dout_last,
    input  logic              dout_ready
);

    localparam int            IW   = $clog2(BLK_BYTES);
    localparam logic [IW-1:0] LAST = IW'(BLK_BYTES - 1);

    strm_state_e       st_q;
    logic [IW-1:0]     idx_q;
    logic [AW-1:0]     base_q;
    logic [ARG_W-1:0]  len_q;
    logic              from_mem_q;
    logic [BYTE_W-1:0] data_q;
    logic              in_win;

    assign in_win = (ARG_W'(idx_q) < len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            idx_q      <= '0;
            base_q     <= '0;
            len_q      <= '0;
            from_mem_q <= 1'b0;
            data_q     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (strm_start) begin
                    base_q <= win_addr;
                    len_q  <= win_len;
                    idx_q  <= '0;
                    st_q   <= ST_FETCH;
                end
                ST_FETCH: begin
                    from_mem_q <= in_win;
                    st_q       <= ST_LOAD;
                end
                ST_LOAD: begin
                    data_q <= from_mem_q ? mem_rdata : '0;
                    st_q   <= ST_SEND;
                end
                ST_SEND: if (dout_ready) begin
                    if (idx_q == LAST) begin
                        st_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                        st_q  <= ST_FETCH;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign strm_busy  = (st_q != ST_IDLE);
    assign mem_req    = (st_q == ST_FETCH) && in_win;
    assign mem_addr   = base_q + AW'(idx_q);
    assign dout_valid = (st_q == ST_SEND);
    assign dout_data  = data_q;
    assign dout_last  = (st_q == ST_SEND) && (idx_q == LAST);

    // R9: an offered byte holds until taken
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !dout_ready) |=> dout_valid && $stable(dout_data) && $stable(dout_last));

    // R8: bytes past the programmed length are zero
    p_pad_r8: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !(ARG_W'(idx_q) < len_q)) |-> dout_data == '0);

    // R8: the stream ends right after the last byte is taken
    p_end_r8: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && dout_last && dout_ready) |=> !dout_valid);

endmodule

// File: rtl/dbgdump_ctrl.sv
module dbgdump_ctrl
    import dbgdump_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BLK_BYTES = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [5:0]    cmd_index,
    input  logic [31:0]   cmd_arg,
    output logic          pass_valid,
    output logic [5:0]    pass_index,
    output logic [31:0]   pass_arg,
    output logic          erase_inhibit,
    output logic          mode_active,
    output logic          rd_error,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          dout_valid,
    output logic [7:0]    dout_data,
    output logic          dout_last,
    input  logic          dout_ready
);

    mmc_cmd_t         cmd;
    mmc_cmd_t         pass_cmd;
    logic             strm_busy;
    logic             strm_start;
    logic [AW-1:0]    win_addr;
    logic [ARG_W-1:0] win_len;

    assign cmd.index = cmd_index;
    assign cmd.arg   = cmd_arg;

    dbgdump_keyseq u_keyseq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .mode_active (mode_active)
    );

    dbgdump_window #(.AW(AW)) u_window (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .mode_active (mode_active),
        .strm_busy   (strm_busy),
        .pass_valid  (pass_valid),
        .pass_cmd    (pass_cmd),
        .rd_error    (rd_error),
        .strm_start  (strm_start),
        .win_addr    (win_addr),
        .win_len     (win_len)
    );

    dbgdump_stream #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_stream (
        .clk        (clk),
        .rst        (rst),
        .strm_start (strm_start),
        .win_addr   (win_addr),
        .win_len    (win_len),
        .strm_busy  (strm_busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .dout_valid (dout_valid),
        .dout_data  (dout_data),
        .dout_last  (dout_last),
        .dout_ready (dout_ready)
    );

    assign pass_index    = pass_cmd.index;
    assign pass_arg      = pass_cmd.arg;
    assign erase_inhibit = mode_active;

    // R6: no erase is ever forwarded for a command accepted during the mode
    p_no_erase_r6: assert property (@(posedge clk) disable iff (rst)
        (pass_valid && pass_index == CMD_ERASE) |-> !$past(mode_active));

endmodule

// File: tb/dbgdump_ctrl_bench.sv
module dbgdump_ctrl_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [5:0]    cmd_index = '0;
    logic [31:0]   cmd_arg = '0;
    logic          pass_valid, erase_inhibit, mode_active, rd_error;
    logic [5:0]    pass_index;
    logic [31:0]   pass_arg;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = '0;
    logic          dout_valid, dout_last;
    logic [7:0]    dout_data;
    logic          dout_ready = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    logic [8:0] expq[$];
    int  cyc = 0;
    logic stall_prev = 1'b0;
    logic [7:0] prev_data = '0;

    always #2.5 clk = ~clk;

    dbgdump_ctrl #(.AW(AW)) u_dbgdump_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .pass_valid(pass_valid), .pass_index(pass_index), .pass_arg(pass_arg),
        .erase_inhibit(erase_inhibit), .mode_active(mode_active), .rd_error(rd_error),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .dout_valid(dout_valid), .dout_data(dout_data), .dout_last(dout_last),
        .dout_ready(dout_ready)
    );

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    // memory model: data one cycle after request
    always @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: drives ready, pops expected bytes on handshakes
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev) begin
                chk("R9", "valid held in stall", dout_valid, 1);
                chk("R9", "data held in stall", dout_data, prev_data);
            end
            cyc++;
            dout_ready = ((cyc * 13) % 7) >= 2;
            if (dout_valid && dout_ready) begin
                if (expq.size() == 0) begin
                    chk("R8", "unexpected byte", {dout_last, dout_data}, 9'h1FF);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    chk("R8", "stream byte/last", {dout_last, dout_data}, e);
                end
            end
            stall_prev = dout_valid && !dout_ready;
            prev_data  = dout_data;
        end
    end

    task automatic push_block(input logic [AW-1:0] addr, input logic [31:0] len);
        for (int k = 0; k < 512; k++) begin
            logic [7:0] d;
            d = (32'(k) < len) ? memf(addr + AW'(k)) : 8'h00;
            expq.push_back({(k == 511), d});
        end
    endtask

    task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg,
                            input logic exp_fwd, input logic exp_err, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, "forwarded", pass_valid, exp_fwd);
        if (exp_fwd) begin
            chk(req, "fwd index", pass_index, idx);
            chk(req, "fwd arg", pass_arg, arg);
        end
        chk(req, "read error", rd_error, exp_err);
    endtask

    task automatic drain();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (expq.size() == 0 && !dout_valid) break;
        end
        chk("R8", "bytes left in scoreboard", expq.size(), 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog all: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "mode_active", mode_active, 0);
        chk("R1", "erase_inhibit", erase_inhibit, 0);
        chk("R1", "pass_valid", pass_valid, 0);
        chk("R1", "rd_error", rd_error, 0);
        chk("R1", "mem_req", mem_req, 0);
        chk("R1", "dout_valid", dout_valid, 0);

        // R2 passthrough outside the mode
        send_cmd(6'd17, 32'h0000_1234, 1, 0, "R2");
        send_cmd(6'd38, 32'h0, 1, 0, "R2");
        send_cmd(6'd62, 32'hCAFE_0001, 1, 0, "R2");

        // R4 mismatching partners and a lone partner
        send_cmd(6'd62, 32'hEFAC_62EC, 1, 0, "R4");
        send_cmd(6'd62, 32'h1021_0003, 1, 0, "R4");
        chk("R4", "mode after bad partner", mode_active, 0);
        send_cmd(6'd62, 32'h1021_0002, 1, 0, "R4");
        chk("R4", "mode after lone partner", mode_active, 0);
        send_cmd(6'd62, 32'hEFAC_62EC, 1, 0, "R4");
        send_cmd(6'd13, 32'h1021_0002, 1, 0, "R4");
        chk("R4", "mode after wrong index", mode_active, 0);

        // R3 entry
        send_cmd(6'd62, 32'hEFAC_62EC, 1, 0, "R3");
        send_cmd(6'd62, 32'h1021_0002, 1, 0, "R3");
        chk("R3", "mode after entry", mode_active, 1);
        chk("R6", "erase_inhibit", erase_inhibit, 1);

        // R10 read before arming; R6 consumed and forwarded commands
        send_cmd(6'd17, 32'h0, 0, 1, "R10");
        send_cmd(6'd13, 32'h0000_0077, 1, 0, "R6");

        // R7 window setup, nonzero erase does not arm
        send_cmd(6'd35, 32'hABCD_1FF0, 0, 0, "R7");
        send_cmd(6'd36, 32'd5, 0, 0, "R7");
        send_cmd(6'd38, 32'h1, 0, 0, "R6");
        send_cmd(6'd17, 32'h0, 0, 1, "R7");
        send_cmd(6'd38, 32'h0, 0, 0, "R6");

        // R8 short window; R10 read while streaming
        push_block(16'h1FF0, 32'd5);
        send_cmd(6'd17, 32'h0, 0, 0, "R8");
        send_cmd(6'd17, 32'h0, 0, 1, "R10");
        drain();

        // R8 address wrap
        send_cmd(6'd35, 32'h0000_FFFE, 0, 0, "R7");
        send_cmd(6'd36, 32'd4, 0, 0, "R7");
        send_cmd(6'd38, 32'h0, 0, 0, "R7");
        push_block(16'hFFFE, 32'd4);
        send_cmd(6'd17, 32'h0, 0, 0, "R8");
        drain();

        // R8 length longer than a block
        send_cmd(6'd36, 32'd600, 0, 0, "R7");
        send_cmd(6'd35, 32'h0000_0100, 0, 0, "R7");
        send_cmd(6'd17, 32'h0, 0, 1, "R7");
        send_cmd(6'd38, 32'h0, 0, 0, "R7");
        push_block(16'h0100, 32'd600);
        send_cmd(6'd17, 32'h0, 0, 0, "R8");
        drain();

        // R8 zero length gives an all-zero block
        send_cmd(6'd36, 32'd0, 0, 0, "R7");
        send_cmd(6'd38, 32'h0, 0, 0, "R7");
        push_block(16'h0100, 32'd0);
        send_cmd(6'd17, 32'h0, 0, 0, "R8");
        drain();

        // R4 mismatch while active keeps the mode
        send_cmd(6'd62, 32'hEFAC_62EC, 0, 0, "R4");
        send_cmd(6'd13, 32'h00DE_CCEE, 1, 0, "R4");
        chk("R4", "mode kept after bad exit", mode_active, 1);

        // R5 exit
        send_cmd(6'd62, 32'hEFAC_62EC, 0, 0, "R5");
        send_cmd(6'd62, 32'h00DE_CCEE, 0, 0, "R5");
        chk("R5", "mode after exit", mode_active, 0);
        chk("R5", "erase_inhibit after exit", erase_inhibit, 0);
        send_cmd(6'd38, 32'h0, 1, 0, "R2");

        // R11 re-entry finds the window disarmed
        send_cmd(6'd62, 32'hEFAC_62EC, 1, 0, "R11");
        send_cmd(6'd62, 32'h1021_0002, 1, 0, "R11");
        chk("R11", "mode after re-entry", mode_active, 1);
        send_cmd(6'd17, 32'h0, 0, 1, "R11");
        repeat (4) @(negedge clk);
        chk("R11", "no stream after refused read", dout_valid, 0);

        summary();
        $finish;
    end

endmodule